// File: doc/BRIEF.md
# Register Bus Width Adapter

This block connects a processor-side bus to a register file. The bus issues byte, halfword or word accesses. Inside the register file every aligned 4-byte group has one fixed native width: byte, halfword or word, or it is unmapped. A constant table, indexed by the group number, holds that width. The adapter turns each bus access into a short sequence of native-width accesses on a simple register port and returns the assembled read data.

There are three cases. A bus access wider than the native width is cut into several narrower accesses, and the most significant part goes to the lowest address. A bus read narrower than the native width fetches the whole register and picks the addressed lane. A bus write narrower than the native width fetches the register, replaces the addressed lane and writes the register back. The adapter takes one request at a time. It issues one register access per clock and signals completion with a one-cycle response pulse.

The controller has five states. `ST_IDLE` accepts a request. `ST_SPLIT` issues the native accesses of an equal or wider transfer. `ST_FETCH` issues the native read of a narrow transfer. `ST_MERGE` writes back the modified register. `ST_FINISH` presents the response. The transitions are:
- `ST_IDLE` to `ST_FINISH` for an offset outside the register space.
- `ST_IDLE` to `ST_SPLIT` when the access is as wide as the native width or wider.
- `ST_IDLE` to `ST_FETCH` when the access is narrower than the native width.
- `ST_SPLIT` stays in `ST_SPLIT` until its last piece, then goes to `ST_FINISH`.
- `ST_FETCH` goes to `ST_MERGE` for a write and to `ST_FINISH` for a read.
- `ST_MERGE` goes to `ST_FINISH`.
- `ST_FINISH` returns to `ST_IDLE`.

Top module: `rbw_bridge`

## Requirements
- R1: `req_ready` is high only while the adapter is idle, and a request is taken when `req_valid` and `req_ready` are both high. Every taken request produces exactly one cycle of `resp_valid`. That cycle comes k+1 clocks after acceptance, where k is the number of register accesses, which are issued on consecutive clocks. No register access is issued in the response cycle.
- R2: Only the low 10 bits of `req_addr` form the offset. An offset from 0x200 to 0x3FF issues no register access, reads as zero and has its write dropped. It does not alias into the register space.
- R3: The native width of the group holding offset `o` comes from a 128-entry table indexed by `o[8:2]`. Its code is `o[5:4]`: 0 means unmapped, 1 byte, 2 halfword and 3 word. Unmapped groups are served as byte-wide. Every register access uses the native size of its group and is aligned to that size.
- R4: Size codes are 0 byte, 1 halfword, 2 word, and 3 is handled as word. A halfword request ignores offset bit 0, and a word request ignores offset bits 1:0.
- R5: An access wider than the native width becomes size/native accesses at ascending addresses. The first access carries the most significant part. For example, a halfword over bytes places bits 15:8 at the lower address, and a word over halfwords places bits 31:16 at the lower address. Read pieces are concatenated in the same order.
- R6: A narrow read issues one native read and returns the addressed lane right-justified and zero-extended. From a halfword register, an even offset returns bits 15:8 and an odd offset returns bits 7:0. From a word register, byte lane 0 is bits 31:24. A halfword from a word register is the upper half when offset bit 1 is clear and the lower half otherwise.
- R7: A narrow write issues one native read and, on the next clock, one native write. The write changes only the addressed lane, with lanes placed as in R6.
- R8: An access whose size equals the native width issues exactly one register access at the aligned offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Adapter idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R4) |
| req_addr | input | ADDR_W | Byte offset; low 10 bits used |
| req_wdata | input | 32 | Write data, right-justified |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, right-justified, valid with resp_valid |
| reg_en | output | 1 | Register access this cycle |
| reg_we | output | 1 | Register access is a write |
| reg_size | output | 2 | Register access size code |
| reg_addr | output | 9 | Register byte offset |
| reg_wdata | output | 32 | Register write data, right-justified |
| reg_rdata | input | 32 | Register read data, returned in the same cycle |

## Verification
The register port is driven by a byte-array model, and a separate shadow array predicts every read in big-endian byte order. Directed transfers cover every pairing of access size and native width, because each pairing selects a different state path: splitting into two or four pieces, lane pick, or read-modify-write. They also cover both byte parities and both halfword halves, which show whether lanes are placed correctly. Seeded random transfers then mix every size with every group and with offsets inside and outside the register space, and the number of register accesses and the response latency are checked for each transfer. A final sweep of word reads over the whole space shows whether any narrow write disturbed a neighbouring lane.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_FETCH,
        ST_MERGE,
        ST_FINISH
    } bridge_st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // size code 3 behaves as a word access
    function automatic logic [1:0] norm_size(input logic [1:0] s);
        return (s == 2'd3) ? SZ_WORD : s;
    endfunction

    // width-table code to access size; unmapped is served as byte
    function automatic logic [1:0] code_to_size(input logic [1:0] c);
        case (c)
            2'd2:    return SZ_HALF;
            2'd3:    return SZ_WORD;
            default: return SZ_BYTE;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/rbw_width_rom.sv
module rbw_width_rom #(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] grp,
    output logic [1:0]       code
);
    localparam int GROUPS = 2 ** IDX_W;

    logic [1:0] rom [GROUPS];

    // constant table: group g carries code g[3:2]
    for (genvar g = 0; g < GROUPS; g++) begin : g_ent
        localparam int CODE = (g >> 2) & 3;
        assign rom[g] = 2'(CODE);
    end

    assign code = rom[grp];

endmodule

// File: rtl/rbw_lane_unit.sv
module rbw_lane_unit
    import rbw_pkg::*;
(
    input  logic [1:0]  acc_size,
    input  logic [1:0]  nat_size,
    input  logic [1:0]  low,
    input  logic [31:0] wide,
    input  logic [31:0] narrow,
    output logic [31:0] picked,
    output logic [31:0] merged
);
    int          nat_b;
    int          acc_b;
    int          ofs;
    logic [4:0]  sh;
    logic [31:0] m;

    // lane 0 is the most significant lane of the native register
    always_comb begin
        nat_b  = 1 << nat_size;
        acc_b  = 1 << acc_size;
        ofs    = int'(low) & (nat_b - 1);
        sh     = (acc_b < nat_b) ? 5'((nat_b - acc_b - ofs) * 8) : 5'd0;
        m      = size_mask(acc_size);
        picked = (wide >> sh) & m;
        merged = (wide & ~(m << sh)) | ((narrow & m) << sh);
    end

endmodule

// File: rtl/rbw_bridge.sv
module rbw_bridge
    import rbw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [OFF_W-2:0]  reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);
    localparam int SP_W  = OFF_W - 1;
    localparam int IDX_W = SP_W - 2;

    bridge_st_e st, st_nx;

    logic            op_we;
    logic [1:0]      op_sz;
    logic [1:0]      op_nat;
    logic [SP_W-1:0] op_addr;
    logic [31:0]     op_wdata;
    logic [31:0]     acc;
    logic [1:0]      step;
    logic [1:0]      last;

    logic [OFF_W-1:0] off;
    logic             in_range;
    logic [1:0]       rq_sz;
    logic [1:0]       rq_code;
    logic [1:0]       rq_nat;
    logic [SP_W-1:0]  rq_addr;
    logic             accept;

    logic [SP_W-1:0]  nat_base;
    logic [31:0]      nat_mask;
    int               nat_bits;
    int               chunk_sh;
    logic [31:0]      lane_wide;
    logic [31:0]      lane_pick;
    logic [31:0]      lane_merge;

    // request decode
    always_comb begin
        off      = req_addr[OFF_W-1:0];
        in_range = ~off[OFF_W-1];
        rq_sz    = norm_size(req_size);
        rq_addr  = off[SP_W-1:0] & ~SP_W'((1 << rq_sz) - 1);
        rq_nat   = code_to_size(rq_code);
        accept   = req_valid && req_ready;
    end

    rbw_width_rom #(.IDX_W(IDX_W)) u_rom (
        .grp  (rq_addr[SP_W-1:2]),
        .code (rq_code)
    );

    assign lane_wide = (st == ST_MERGE) ? acc : reg_rdata;

    rbw_lane_unit u_lane (
        .acc_size (op_sz),
        .nat_size (op_nat),
        .low      (op_addr[1:0]),
        .wide     (lane_wide),
        .narrow   (op_wdata),
        .picked   (lane_pick),
        .merged   (lane_merge)
    );

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (!in_range)            st_nx = ST_FINISH;
                    else if (rq_sz >= rq_nat) st_nx = ST_SPLIT;
                    else                      st_nx = ST_FETCH;
                end
            end
            ST_SPLIT:  st_nx = (step == last) ? ST_FINISH : ST_SPLIT;
            ST_FETCH:  st_nx = op_we ? ST_MERGE : ST_FINISH;
            ST_MERGE:  st_nx = ST_FINISH;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register and transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            op_we    <= 1'b0;
            op_sz    <= SZ_BYTE;
            op_nat   <= SZ_BYTE;
            op_addr  <= '0;
            op_wdata <= '0;
            acc      <= '0;
            step     <= '0;
            last     <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                op_we    <= req_we;
                op_sz    <= rq_sz;
                op_nat   <= rq_nat;
                op_addr  <= rq_addr;
                op_wdata <= req_wdata;
                acc      <= '0;
                step     <= '0;
                last     <= (rq_sz >= rq_nat) ? 2'((1 << (rq_sz - rq_nat)) - 1) : 2'd0;
            end
            if (st == ST_SPLIT) begin
                acc  <= (acc << nat_bits) | (reg_rdata & nat_mask);
                step <= step + 2'd1;
            end
            if (st == ST_FETCH) begin
                acc <= op_we ? reg_rdata : lane_pick;
            end
        end
    end

    // outputs
    always_comb begin
        nat_bits   = 8 << op_nat;
        nat_mask   = size_mask(op_nat);
        nat_base   = op_addr & ~SP_W'((1 << op_nat) - 1);
        chunk_sh   = int'(last - step) * nat_bits;
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_rdata = '0;
        reg_en     = 1'b0;
        reg_we     = 1'b0;
        reg_size   = op_nat;
        reg_addr   = nat_base;
        reg_wdata  = '0;
        unique case (st)
            ST_IDLE: req_ready = 1'b1;
            ST_SPLIT: begin
                reg_en    = 1'b1;
                reg_we    = op_we;
                reg_addr  = op_addr + (SP_W'(step) << op_nat);
                reg_wdata = (op_wdata >> chunk_sh) & nat_mask;
            end
            ST_FETCH: reg_en = 1'b1;
            ST_MERGE: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = lane_merge;
            end
            ST_FINISH: begin
                resp_valid = 1'b1;
                resp_rdata = op_we ? 32'h0 : acc;
            end
            default: req_ready = 1'b0;
        endcase
    end

    // independent lookup of the emitted register address
    logic [1:0] chk_code;

    rbw_width_rom #(.IDX_W(IDX_W)) u_chk_rom (
        .grp  (reg_addr[SP_W-1:2]),
        .code (chk_code)
    );

    // R1
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (!reg_en && !req_ready));

    // R2
    oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr[OFF_W-1]) |=> (resp_valid && resp_rdata == 32'h0));

    // R3
    sub_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> (reg_size == code_to_size(chk_code)));

    // R3
    sub_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> ((reg_addr & SP_W'((1 << reg_size) - 1)) == '0));

    // R6
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !op_we && op_sz == SZ_BYTE) |-> (resp_rdata[31:8] == 24'h0));

    // R7
    rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MERGE) |-> (reg_en && reg_we && $past(reg_en && !reg_we)));

endmodule

// File: tb/test_rbw_bridge.sv
`timescale 1ns/1ps
module test_rbw_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_we;
    logic [1:0]  req_size;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        reg_en;
    logic        reg_we;
    logic [1:0]  reg_size;
    logic [8:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    always #2.5 clk = ~clk;

    rbw_bridge i_rbw_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_size   (reg_size),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    logic [7:0] mem    [512];
    logic [7:0] shadow [512];
    int total = 0;
    int bad   = 0;
    int sub_cnt = 0;
    int bad_sub = 0;
    bit finished = 1'b0;

    function automatic int size_bytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // R3: code = offset bits 5:4
    function automatic int native_bytes(input int o);
        case ((o >> 4) & 3)
            2: return 2;
            3: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [1:0] native_code(input int o);
        int n;
        n = native_bytes(o);
        return (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
    endfunction

    // register file model, big-endian bytes, data right-justified
    always_comb begin
        case (reg_size)
            2'd0:    reg_rdata = {24'h0, mem[reg_addr]};
            2'd1:    reg_rdata = {16'h0, mem[reg_addr], mem[reg_addr + 9'd1]};
            default: reg_rdata = {mem[reg_addr], mem[reg_addr + 9'd1],
                                  mem[reg_addr + 9'd2], mem[reg_addr + 9'd3]};
        endcase
    end

    always @(posedge clk) begin
        if (rst_n && reg_en) begin
            sub_cnt <= sub_cnt + 1;
            if (reg_size != native_code(int'(reg_addr)) ||
                (int'(reg_addr) % size_bytes(reg_size)) != 0)
                bad_sub <= bad_sub + 1;
            if (reg_we) begin
                case (reg_size)
                    2'd0: mem[reg_addr] <= reg_wdata[7:0];
                    2'd1: begin
                        mem[reg_addr]        <= reg_wdata[15:8];
                        mem[reg_addr + 9'd1] <= reg_wdata[7:0];
                    end
                    default: begin
                        mem[reg_addr]        <= reg_wdata[31:24];
                        mem[reg_addr + 9'd1] <= reg_wdata[23:16];
                        mem[reg_addr + 9'd2] <= reg_wdata[15:8];
                        mem[reg_addr + 9'd3] <= reg_wdata[7:0];
                    end
                endcase
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic xfer(input string tag, input bit we, input logic [1:0] sz,
                        input logic [15:0] addr, input logic [31:0] wd);
        int off, sb, a, nb, esubs, s0, b0, lat;
        bit oor;
        logic [31:0] exp;
        off = int'(addr) & 'h3FF;
        oor = (off >= 'h200);
        sb  = size_bytes(sz);
        a   = off & ~(sb - 1) & 'h1FF;
        nb  = native_bytes(a);
        exp = 32'h0;
        esubs = oor ? 0 : (sb >= nb) ? (sb / nb) : (we ? 2 : 1);
        if (!oor) begin
            for (int i = 0; i < sb; i++) begin
                if (we) shadow[a + i] = wd[8 * (sb - 1 - i) +: 8];
                else    exp = (exp << 8) | 32'(shadow[a + i]);
            end
        end
        @(negedge clk);
        s0 = sub_cnt;
        b0 = bad_sub;
        req_valid = 1'b1;
        req_we    = we;
        req_size  = sz;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 30) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R1 latency"}, 32'(lat), 32'(esubs + 1));
        check({tag, " R8 R5 access count"}, 32'(sub_cnt - s0), 32'(esubs));
        check({tag, " R3 native size and alignment"}, 32'(bad_sub - b0), 32'h0);
        if (!we) check({tag, " R6 read data"}, resp_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_we    = 1'b0;
        req_size  = 2'd0;
        req_addr  = '0;
        req_wdata = '0;
        for (int i = 0; i < 512; i++) begin
            mem[i]    = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        check("R1 reset ready", 32'(req_ready), 32'h1);
        check("R1 reset resp_valid", 32'(resp_valid), 32'h0);
        check("R1 reset reg_en", 32'(reg_en), 32'h0);
        rst_n = 1'b1;

        // equal widths
        xfer("R8 byte on byte",  1'b0, 2'd0, 16'h0013, 32'h0);
        xfer("R8 half on half",  1'b0, 2'd1, 16'h0022, 32'h0);
        xfer("R8 word on word",  1'b0, 2'd2, 16'h0038, 32'h0);
        // splitting
        xfer("R5 half over bytes",       1'b0, 2'd1, 16'h0010, 32'h0);
        xfer("R5 word over bytes",       1'b0, 2'd2, 16'h0014, 32'h0);
        xfer("R5 word over halves",      1'b0, 2'd2, 16'h0024, 32'h0);
        xfer("R3 word over unmapped",    1'b0, 2'd2, 16'h0004, 32'h0);
        xfer("R5 half write over bytes", 1'b1, 2'd1, 16'h0018, 32'hA1B2);
        xfer("R5 word write over halves",1'b1, 2'd2, 16'h0028, 32'hC3D4E5F6);
        xfer("R5 readback bytes",        1'b0, 2'd2, 16'h0018, 32'h0);
        xfer("R5 readback halves",       1'b0, 2'd2, 16'h0028, 32'h0);
        // lane picking
        xfer("R6 byte even of half", 1'b0, 2'd0, 16'h0020, 32'h0);
        xfer("R6 byte odd of half",  1'b0, 2'd0, 16'h0021, 32'h0);
        for (int l = 0; l < 4; l++)
            xfer("R6 byte lane of word", 1'b0, 2'd0, 16'h0030 + 16'(l), 32'h0);
        xfer("R6 upper half of word", 1'b0, 2'd1, 16'h0030, 32'h0);
        xfer("R6 lower half of word", 1'b0, 2'd1, 16'h0032, 32'h0);
        xfer("R4 odd half offset",    1'b0, 2'd1, 16'h0033, 32'h0);
        xfer("R4 size code 3",        1'b0, 2'd3, 16'h003E, 32'h0);
        // read-modify-write
        xfer("R7 byte into half", 1'b1, 2'd0, 16'h0025, 32'h0000005A);
        xfer("R7 byte into word", 1'b1, 2'd0, 16'h0036, 32'h000000C7);
        xfer("R7 half into word", 1'b1, 2'd1, 16'h003A, 32'h00009E01);
        xfer("R7 readback half",  1'b0, 2'd2, 16'h0024, 32'h0);
        xfer("R7 readback word",  1'b0, 2'd2, 16'h0034, 32'h0);
        xfer("R7 readback word2", 1'b0, 2'd2, 16'h0038, 32'h0);
        // out-of-space offsets and masking
        xfer("R2 read above space",   1'b0, 2'd2, 16'h02F0, 32'h0);
        xfer("R2 write above space",  1'b1, 2'd2, 16'h0210, 32'hDEADBEEF);
        xfer("R2 no alias",           1'b0, 2'd2, 16'h0010, 32'h0);
        xfer("R2 high bits masked",   1'b1, 2'd1, 16'hFC12, 32'h7788);
        xfer("R2 masked readback",    1'b0, 2'd1, 16'h0012, 32'h0);

        for (int n = 0; n < 400; n++) begin
            xfer("random", 1'($urandom), 2'($urandom), 16'($urandom), $urandom);
        end

        for (int w = 0; w < 128; w++)
            xfer("R7 final sweep", 1'b0, 2'd2, 16'(w * 4), 32'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule